// File: doc/BRIEF.md
# Strap and Revision Register Slice

This block is a small memory-mapped register slice for system control. It holds a hardware strapping word and a silicon revision word. It sits on a simple register bus with an address, separate read and write enables, write data, registered read data and an error flag. At reset the revision word is taken from input pins and the strap word is taken from a second set of pins. After reset the bus can read both words, but only the strap word can be modified.

How the strap word takes a write depends on the chip generation that the revision word encodes. The generation is decided by comparing the top byte of the revision word with a parameterized code. On the newer generation, a write to the strap address sets only the bits written as 1. A write to the revision address leaves the revision word as it is and clears the strap bits written as 1. On the older generation, a write to the strap address replaces the whole strap word. A write to the revision address is refused as a write to a read-only location.

Top module: `strap_regs`

## Requirements
- R1: While rstN is low, the strap word loads strapInit and the revision word loads revIn. After reset, rdData is zero and busErr is low until the first access.
- R2: The newer generation is selected when revision bits [31:24] equal NEW_GEN_CODE (default 8'h04). On the newer generation, a write to offset 0x70 makes the strap word the bitwise OR of its old value and wrData.
- R3: On the newer generation, a write to offset 0x7C clears every strap bit whose wrData bit is 1 (strap = strap & ~wrData) and does not assert busErr.
- R4: On the older generation (any other value of bits [31:24]), a write to offset 0x70 replaces the whole strap word with wrData.
- R5: On the older generation, a write to offset 0x7C leaves the strap word unchanged and drives busErr high in the following cycle.
- R6: No bus write changes the revision word on either generation.
- R7: A read with rdEn high at a clock edge drives rdData in the next cycle: the strap word for offset 0x70, the revision word for 0x7C. A read in the cycle after a write returns the updated strap word.
- R8: A read or write at any offset other than 0x70 and 0x7C changes no state. It gives rdData of zero and drives busErr high in the next cycle.
- R9: A cycle with neither rdEn nor wrEn high gives rdData of zero and busErr low in the next cycle. Back-to-back set and clear of the same strap bit apply in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; loads the strap and revision words |
| revIn | input | 32 | Revision word loaded at reset |
| strapInit | input | 32 | Initial strap word loaded at reset |
| addr | input | 8 | Byte offset of the access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, one cycle after rdEn |
| busErr | output | 1 | Registered error flag for the previous cycle's access |

## Verification
A wrong strap bit is not visible at the ports until a read of 0x70, and it then shows in the cycle after that read. For this reason the vector walk reads the strap word after every group of set, clear and overwrite operations. A wrong generation decision appears one cycle after the first write to 0x70 or 0x7C, either as a wrong strap value on the next read or as busErr being asserted or missing. A corrupted revision word shows on the next read of 0x7C. It also changes the generation decision, so a later strap write shows it too.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Strobes from the decode/control half to the register datapath
  typedef struct packed {
    logic setStrap;   // OR write data into strap word
    logic clrStrap;   // clear strap bits written as 1
    logic loadStrap;  // overwrite strap word
    logic selStrap;   // read strap word
    logic selRev;     // read revision word
    logic accErr;     // access error for this cycle
  } strobe_t;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int GEN_W        = 8,
  parameter logic [GEN_W-1:0] NEW_GEN_CODE = 8'h04,
  parameter logic [ADDR_W-1:0] STRAP_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] REV_OFS   = 8'h7C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] revWord,
  output strobe_t           stb
);

  localparam int GEN_LO = DATA_W - GEN_W;

  logic newGen;
  logic hitStrap;
  logic hitRev;
  logic anyAcc;

  assign newGen   = (revWord[DATA_W-1:GEN_LO] == NEW_GEN_CODE);
  assign hitStrap = (addr == STRAP_OFS);
  assign hitRev   = (addr == REV_OFS);
  assign anyAcc   = wrEn | rdEn;

  always_comb begin
    stb = '0;
    if (wrEn && hitStrap) begin
      if (newGen) stb.setStrap  = 1'b1;
      else        stb.loadStrap = 1'b1;
    end
    if (wrEn && hitRev) begin
      if (newGen) stb.clrStrap = 1'b1;
      else        stb.accErr   = 1'b1;
    end
    if (rdEn && hitStrap) stb.selStrap = 1'b1;
    if (rdEn && hitRev)   stb.selRev   = 1'b1;
    if (anyAcc && !hitStrap && !hitRev) stb.accErr = 1'b1;
  end

endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] revIn,
  input  logic [DATA_W-1:0] strapInit,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] strapWord,
  output logic [DATA_W-1:0] revWord,
  output logic [DATA_W-1:0] rdData,
  output logic              busErr
);

  logic [DATA_W-1:0] strapNext;

  // Per-bit strap update: overwrite, set-on-one or clear-on-one
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      if (stb.loadStrap)                   strapNext[b] = wrData[b];
      else if (stb.setStrap && wrData[b])  strapNext[b] = 1'b1;
      else if (stb.clrStrap && wrData[b])  strapNext[b] = 1'b0;
      else                                 strapNext[b] = strapWord[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapWord <= strapInit;
      revWord   <= revIn;
    end else begin
      strapWord <= strapNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      busErr <= 1'b0;
    end else begin
      if (stb.selStrap)    rdData <= strapWord;
      else if (stb.selRev) rdData <= revWord;
      else                 rdData <= '0;
      busErr <= stb.accErr;
    end
  end

endmodule

// File: rtl/strap_regs.sv
module strap_regs
  import strap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int GEN_W  = 8,
  parameter logic [GEN_W-1:0]  NEW_GEN_CODE = 8'h04,
  parameter logic [ADDR_W-1:0] STRAP_OFS    = 8'h70,
  parameter logic [ADDR_W-1:0] REV_OFS      = 8'h7C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] revIn,
  input  logic [DATA_W-1:0] strapInit,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busErr
);

  strobe_t           stb;
  logic [DATA_W-1:0] strapWord;
  logic [DATA_W-1:0] revWord;

  strap_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GEN_W(GEN_W),
    .NEW_GEN_CODE(NEW_GEN_CODE), .STRAP_OFS(STRAP_OFS), .REV_OFS(REV_OFS)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .revWord(revWord), .stb(stb)
  );

  strap_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .revIn(revIn), .strapInit(strapInit),
    .wrData(wrData), .stb(stb), .strapWord(strapWord), .revWord(revWord),
    .rdData(rdData), .busErr(busErr)
  );

endmodule

// File: rtl/strap_chk.sv
module strap_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int GEN_W  = 8,
  parameter logic [GEN_W-1:0]  NEW_GEN_CODE = 8'h04,
  parameter logic [ADDR_W-1:0] STRAP_OFS    = 8'h70,
  parameter logic [ADDR_W-1:0] REV_OFS      = 8'h7C
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              busErr,
  input logic [DATA_W-1:0] strapWord,
  input logic [DATA_W-1:0] revWord
);

  logic isNew;
  logic mapped;
  assign isNew  = (revWord[DATA_W-1:DATA_W-GEN_W] == NEW_GEN_CODE);
  assign mapped = (addr == STRAP_OFS) || (addr == REV_OFS);

  // R6
  rev_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(revWord));

  // R2
  set_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == STRAP_OFS && isNew) |=>
      strapWord == ($past(strapWord) | $past(wrData)));

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REV_OFS && isNew) |=>
      (strapWord == ($past(strapWord) & ~$past(wrData))) && !busErr);

  // R5
  ro_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REV_OFS && !isNew) |=> busErr && $stable(strapWord));

  // R8
  unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn || rdEn) && !mapped) |=> busErr && rdData == '0 && $stable(strapWord));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn) |=> !busErr && rdData == '0);

  // R7
  rd_strap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == STRAP_OFS) |=> rdData == $past(strapWord));

endmodule

bind strap_regs strap_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GEN_W(GEN_W),
  .NEW_GEN_CODE(NEW_GEN_CODE), .STRAP_OFS(STRAP_OFS), .REV_OFS(REV_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .busErr(busErr),
  .strapWord(strapWord), .revWord(revWord)
);

// File: tb/sim_strap_regs.sv
`timescale 1ns/1ps
module sim_strap_regs;

  localparam logic [31:0] REV_NEW   = 32'h0400_0303;
  localparam logic [31:0] REV_OLD   = 32'h0201_0303;
  localparam logic [31:0] STRAP_INI = 32'hF100_C2E0;
  localparam logic [7:0]  A_STRAP   = 8'h70;
  localparam logic [7:0]  A_REV     = 8'h7C;

  // op: 0 idle, 1 write, 2 read
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  ad;
    logic [31:0] dt;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 8'h70, 32'h0},
    '{2'd1, 8'h70, 32'h0000_000F},
    '{2'd2, 8'h70, 32'h0},
    '{2'd1, 8'h7C, 32'hF000_0003},
    '{2'd2, 8'h70, 32'h0},
    '{2'd2, 8'h7C, 32'h0},
    '{2'd1, 8'h70, 32'h0001_0000},
    '{2'd1, 8'h7C, 32'h0001_0000},
    '{2'd2, 8'h70, 32'h0},
    '{2'd1, 8'h7C, 32'h0000_0100},
    '{2'd1, 8'h70, 32'h0000_0100},
    '{2'd2, 8'h70, 32'h0},
    '{2'd0, 8'h00, 32'h0},
    '{2'd2, 8'h40, 32'h0},
    '{2'd1, 8'h74, 32'hFFFF_FFFF},
    '{2'd2, 8'h70, 32'h0},
    '{2'd1, 8'h70, 32'h1234_5678},
    '{2'd2, 8'h7C, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] revIn = REV_NEW;
  logic [31:0] strapInit = STRAP_INI;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        busErr;

  int nChk = 0;
  int nFail = 0;
  logic [31:0] mStrap;
  logic [31:0] mRev;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strap_regs u0 (
    .clk(clk), .rstN(rstN), .revIn(revIn), .strapInit(strapInit),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .busErr(busErr)
  );

  task automatic check(string tag, logic [31:0] gotD, logic [31:0] expD,
                       logic gotE, logic expE);
    nChk++;
    if (gotD !== expD || gotE !== expE) begin
      nFail++;
      $display("FAIL %s: rdData=%h busErr=%b expected rdData=%h busErr=%b",
               tag, gotD, gotE, expD, expE);
    end
  endtask

  task automatic doReset(logic [31:0] rv);
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    rstN = 0; revIn = rv; strapInit = STRAP_INI;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    mStrap = STRAP_INI; mRev = rv;
    @(negedge clk);
    check("R1 reset outputs", rdData, 32'h0, busErr, 1'b0);
  endtask

  // One bus cycle, checked at the negedge after the sampling edge
  task automatic doOp(logic [1:0] op, logic [7:0] ad, logic [31:0] dt);
    logic newG, mapd, eErr;
    logic [31:0] eRd;
    string tag;
    newG = (mRev[31:24] == 8'h04);
    mapd = (ad == A_STRAP) || (ad == A_REV);
    eErr = (op != 0 && !mapd) || (op == 1 && ad == A_REV && !newG);
    eRd  = (op == 2 && ad == A_STRAP) ? mStrap :
           (op == 2 && ad == A_REV)   ? mRev : 32'h0;
    if (op == 0)                       tag = "R9 idle";
    else if (!mapd)                    tag = "R8 unmapped";
    else if (op == 2)                  tag = "R7 read";
    else if (ad == A_STRAP && newG)    tag = "R2 set";
    else if (ad == A_STRAP)            tag = "R4 overwrite";
    else if (newG)                     tag = "R3 clear alias";
    else                               tag = "R5 read-only reject";
    addr = ad; wrData = dt; wrEn = (op == 1); rdEn = (op == 2);
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    check(tag, rdData, eRd, busErr, eErr);
    if (op == 1 && ad == A_STRAP) mStrap = newG ? (mStrap | dt) : dt;
    if (op == 1 && ad == A_REV && newG) mStrap = mStrap & ~dt;
  endtask

  initial begin
    // newer generation
    doReset(REV_NEW);
    for (int i = 0; i < NV; i++) doOp(VEC[i].op, VEC[i].ad, VEC[i].dt);
    // R9: set then clear same bit back to back, then read
    doOp(2'd1, A_STRAP, 32'h0000_0040);
    doOp(2'd1, A_REV,   32'h0000_0040);
    doOp(2'd2, A_STRAP, 32'h0);
    check("R9 set-clear same bit", rdData, mStrap, busErr, 1'b0);
    // R6: revision unchanged after alias writes
    doOp(2'd2, A_REV, 32'h0);
    check("R6 rev after writes", rdData, REV_NEW, busErr, 1'b0);

    // older generation
    doReset(REV_OLD);
    for (int i = 0; i < NV; i++) doOp(VEC[i].op, VEC[i].ad, VEC[i].dt);
    doOp(2'd1, A_REV, 32'hFFFF_FFFF);
    doOp(2'd2, A_STRAP, 32'h0);
    check("R5 strap kept", rdData, 32'h1234_5678, busErr, 1'b0);
    doOp(2'd2, A_REV, 32'h0);
    check("R6 rev old gen", rdData, REV_OLD, busErr, 1'b0);
    doOp(2'd1, A_STRAP, 32'h0000_0001);
    doOp(2'd2, A_STRAP, 32'h0);
    check("R4 overwrite then read", rdData, 32'h0000_0001, busErr, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule